// File: doc/BRIEF.md
# Exception Entry State Sequencer

This block decides, once per clock, whether a 32-bit processor core enters an exception and, if so, produces in a single edge the full set of state the core must adopt. It handles two causes. The first is an external interrupt request, which is gated by the interrupt-enable bit of the current machine state word. The second is an alignment fault, raised by some memory instruction classes when the operand address is not a multiple of four. The alignment check is combinational and is also sent straight back to the execute stage, so that the faulting access can be cancelled in the same cycle.

When an exception is taken, the block registers four values: the saved program counter (save/restore word 0), the saved status (save/restore word 1), the rewritten machine state word and the vector fetch address. A one-cycle `taken_o` pulse comes with them, and the fetch unit uses it to redirect. The registered values are held until the next exception. Bit numbering in this document is big-endian: bit 0 is the most significant bit of a 32-bit word.

Top module: `exc_entry_seq`

## Requirements
- R1: While reset is asserted, and on the first cycle after it, `taken_o`, `cause_align_o`, `vec_o`, `srr0_o`, `srr1_o` and `msr_o` are all zero.
- R2: `mem_fault_o` is high in the same cycle when `mem_valid_i` is high, `mem_cls_i` is one of floating-point load/store (code 2), load/store-multiple (code 3) or load-reserve/store-conditional (code 4), and `mem_ea_i[1:0]` is not zero. Code 0 (no memory operation) and code 1 (integer load/store) never fault. A fault leads to an alignment exception on the next edge.
- R3: An external interrupt is taken only when `irq_req_i` is high and the enable bit EE (bit 16 of `msr_i`) is set.
- R4: When an alignment fault and an enabled interrupt occur in the same cycle, the alignment exception is taken and `cause_align_o` is 1. For an external interrupt, `cause_align_o` is 0.
- R5: `vec_o` is the base plus an offset. The base is 0xFFF00000 if IP (bit 25 of `msr_i`) is set, and 0 otherwise. The offset is 0x500 for an external interrupt and 0x600 for an alignment exception.
- R6: `srr0_o` receives `next_pc_i` for an external interrupt, and `cur_pc_i` (the faulting instruction) for an alignment exception.
- R7: `srr1_o` bits 0..15 are cleared, and bits 16..31 are copied from `msr_i`. This includes bit 30, the recoverable bit, which therefore reads zero only when a zero is copied.
- R8: The new `msr_o` keeps IP (bit 25) and ME (bit 19). LE (bit 31) takes the old ILE (bit 15). The compression-enable bit (bit 29) is `cfg_cmp_en_i & cfg_cmp_exc_i`. Every other bit is zero.
- R9: All outputs update on the single edge that follows the triggering cycle, and `taken_o` is high for exactly that one cycle. If no exception is taken, `vec_o`, `srr0_o`, `srr1_o`, `msr_o` and `cause_align_o` keep their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| irq_req_i | input | 1 | External interrupt request (level) |
| mem_valid_i | input | 1 | A memory instruction is in the execute stage |
| mem_cls_i | input | 3 | Instruction class: 0 none, 1 integer, 2 floating-point, 3 multiple, 4 reserve/conditional |
| mem_ea_i | input | 32 | Operand effective address |
| cur_pc_i | input | 32 | Address of the instruction now executing |
| next_pc_i | input | 32 | Address of the instruction that would execute next |
| msr_i | input | 32 | Current machine state word |
| cfg_cmp_en_i | input | 1 | Compression enable configuration |
| cfg_cmp_exc_i | input | 1 | Compression on exception configuration |
| mem_fault_o | output | 1 | Combinational alignment fault, used to suppress the access |
| taken_o | output | 1 | One-cycle pulse when an exception is entered |
| cause_align_o | output | 1 | 1 if the last exception was an alignment exception |
| vec_o | output | 32 | Vector fetch address |
| srr0_o | output | 32 | Saved program counter |
| srr1_o | output | 32 | Saved status |
| msr_o | output | 32 | Rewritten machine state word |

## Verification
The checker assumes that `mem_cls_i` carries only the codes 0 to 4. It also assumes that every input settles before the rising edge and holds across it, because the interrupt-gating property compares the registered cause with the previous cycle's `msr_i` and `irq_req_i`. The bench drives all inputs on the falling edge, uses only the legal class codes, and samples registered results one falling edge after the update. Each pattern is chosen so that the expected cause is unambiguous, including the case where an interrupt and a fault coincide.

// File: rtl/exc_entry_pkg.sv
package exc_entry_pkg;

    localparam int unsigned XLEN = 32;

    // Bit positions are given in big-endian numbering and converted to LSB index.
    function automatic int unsigned be_bit(input int unsigned n);
        return XLEN - 1 - n;
    endfunction

    localparam int unsigned MSR_ILE = be_bit(15);
    localparam int unsigned MSR_EE  = be_bit(16);
    localparam int unsigned MSR_ME  = be_bit(19);
    localparam int unsigned MSR_IP  = be_bit(25);
    localparam int unsigned MSR_CE  = be_bit(29);
    localparam int unsigned MSR_RI  = be_bit(30);
    localparam int unsigned MSR_LE  = be_bit(31);

    // Save/restore word 1 keeps the low half (big-endian bits 16..31).
    localparam int unsigned SRR1_KEEP = XLEN / 2;

    typedef enum logic [2:0] {
        CLS_NONE = 3'd0,
        CLS_INT  = 3'd1,
        CLS_FP   = 3'd2,
        CLS_LSM  = 3'd3,
        CLS_LRSC = 3'd4
    } mem_cls_e;

    typedef struct packed {
        logic [XLEN-1:0] msr;
        logic [XLEN-1:0] srr0;
        logic [XLEN-1:0] srr1;
        logic [XLEN-1:0] vec;
        logic            taken;
        logic            cause_align;
    } entry_state_t;

endpackage

// File: rtl/exc_align_chk.sv
module exc_align_chk
    import exc_entry_pkg::*;
#(
    parameter int unsigned ALIGN_BYTES = 4
) (
    input  logic            valid_i,
    input  logic [2:0]      cls_i,
    input  logic [XLEN-1:0] ea_i,
    output logic            fault_o
);
    localparam int unsigned LOW_BITS = $clog2(ALIGN_BYTES);

    logic checked_cls;
    logic misaligned;

    always_comb begin
        unique case (mem_cls_e'(cls_i))
            CLS_FP, CLS_LSM, CLS_LRSC: checked_cls = 1'b1;
            default:                   checked_cls = 1'b0;
        endcase
    end

    assign misaligned = |ea_i[LOW_BITS-1:0];
    assign fault_o    = valid_i & checked_cls & misaligned;

endmodule

// File: rtl/exc_msr_xform.sv
module exc_msr_xform
    import exc_entry_pkg::*;
(
    input  logic [XLEN-1:0] msr_i,
    input  logic            cmp_en_i,
    input  logic            cmp_exc_i,
    output logic [XLEN-1:0] msr_new_o,
    output logic [XLEN-1:0] srr1_new_o
);
    // Per-bit rewrite of the machine state word.
    for (genvar b = 0; b < XLEN; b++) begin : g_msr_bit
        if (b == MSR_IP || b == MSR_ME) begin : g_keep
            assign msr_new_o[b] = msr_i[b];
        end else if (b == MSR_LE) begin : g_le
            assign msr_new_o[b] = msr_i[MSR_ILE];
        end else if (b == MSR_CE) begin : g_ce
            assign msr_new_o[b] = cmp_en_i & cmp_exc_i;
        end else begin : g_clr
            assign msr_new_o[b] = 1'b0;
        end
    end

    // Saved status: upper half cleared, lower half copied (RI included).
    for (genvar b = 0; b < XLEN; b++) begin : g_srr1_bit
        if (b < SRR1_KEEP) begin : g_copy
            assign srr1_new_o[b] = msr_i[b];
        end else begin : g_zero
            assign srr1_new_o[b] = 1'b0;
        end
    end

endmodule

// File: rtl/exc_vec_gen.sv
module exc_vec_gen
    import exc_entry_pkg::*;
#(
    parameter logic [XLEN-1:0] HI_BASE   = 32'hFFF0_0000,
    parameter logic [XLEN-1:0] OFF_EXT   = 32'h0000_0500,
    parameter logic [XLEN-1:0] OFF_ALIGN = 32'h0000_0600
) (
    input  logic            ip_i,
    input  logic            is_align_i,
    output logic [XLEN-1:0] vec_o
);
    logic [XLEN-1:0] base;
    logic [XLEN-1:0] offset;

    assign base   = ip_i ? HI_BASE : '0;
    assign offset = is_align_i ? OFF_ALIGN : OFF_EXT;
    assign vec_o  = base + offset;

endmodule

// File: rtl/exc_entry_seq.sv
module exc_entry_seq
    import exc_entry_pkg::*;
#(
    parameter int unsigned     ALIGN_BYTES = 4,
    parameter logic [31:0]     HI_BASE     = 32'hFFF0_0000,
    parameter logic [31:0]     OFF_EXT     = 32'h0000_0500,
    parameter logic [31:0]     OFF_ALIGN   = 32'h0000_0600
) (
    input  logic        clk_i,
    input  logic        rst_ni,
    input  logic        irq_req_i,
    input  logic        mem_valid_i,
    input  logic [2:0]  mem_cls_i,
    input  logic [31:0] mem_ea_i,
    input  logic [31:0] cur_pc_i,
    input  logic [31:0] next_pc_i,
    input  logic [31:0] msr_i,
    input  logic        cfg_cmp_en_i,
    input  logic        cfg_cmp_exc_i,
    output logic        mem_fault_o,
    output logic        taken_o,
    output logic        cause_align_o,
    output logic [31:0] vec_o,
    output logic [31:0] srr0_o,
    output logic [31:0] srr1_o,
    output logic [31:0] msr_o
);
    entry_state_t    st_d, st_q;
    logic            fault;
    logic            irq_ok;
    logic [XLEN-1:0] msr_new;
    logic [XLEN-1:0] srr1_new;
    logic [XLEN-1:0] vec_new;

    exc_align_chk #(.ALIGN_BYTES(ALIGN_BYTES)) u_align (
        .valid_i (mem_valid_i),
        .cls_i   (mem_cls_i),
        .ea_i    (mem_ea_i),
        .fault_o (fault)
    );

    exc_msr_xform u_xform (
        .msr_i      (msr_i),
        .cmp_en_i   (cfg_cmp_en_i),
        .cmp_exc_i  (cfg_cmp_exc_i),
        .msr_new_o  (msr_new),
        .srr1_new_o (srr1_new)
    );

    exc_vec_gen #(
        .HI_BASE   (HI_BASE),
        .OFF_EXT   (OFF_EXT),
        .OFF_ALIGN (OFF_ALIGN)
    ) u_vec (
        .ip_i       (msr_i[MSR_IP]),
        .is_align_i (fault),
        .vec_o      (vec_new)
    );

    assign irq_ok = irq_req_i & msr_i[MSR_EE];

    always_comb begin
        st_d       = st_q;
        st_d.taken = 1'b0;
        if (fault || irq_ok) begin
            st_d.taken       = 1'b1;
            st_d.cause_align = fault;
            st_d.srr0        = fault ? cur_pc_i : next_pc_i;
            st_d.srr1        = srr1_new;
            st_d.msr         = msr_new;
            st_d.vec         = vec_new;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign mem_fault_o   = fault;
    assign taken_o       = st_q.taken;
    assign cause_align_o = st_q.cause_align;
    assign vec_o         = st_q.vec;
    assign srr0_o        = st_q.srr0;
    assign srr1_o        = st_q.srr1;
    assign msr_o         = st_q.msr;

endmodule

// File: rtl/exc_entry_seq_chk.sv
module exc_entry_seq_chk
    import exc_entry_pkg::*;
(
    input logic        clk_i,
    input logic        rst_ni,
    input logic        irq_req_i,
    input logic [31:0] msr_i,
    input logic        mem_fault_o,
    input logic        taken_o,
    input logic        cause_align_o,
    input logic [31:0] vec_o,
    input logic [31:0] srr0_o,
    input logic [31:0] srr1_o,
    input logic [31:0] msr_o
);
    localparam logic [31:0] MSR_MAY_SET =
        (32'd1 << MSR_IP) | (32'd1 << MSR_ME) | (32'd1 << MSR_LE) | (32'd1 << MSR_CE);

    // R2: a fault leads to an alignment entry on the next edge
    assert_fault_enters_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        mem_fault_o |=> (taken_o && cause_align_o));

    // R3: an external entry needs an enabled request in the triggering cycle
    assert_irq_gated_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (taken_o && !cause_align_o) |-> ($past(irq_req_i) && $past(msr_i[MSR_EE])));

    // R5: the low part of the vector is one of the two fixed offsets
    assert_vec_offset_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        taken_o |-> (vec_o[19:0] == (cause_align_o ? 20'h00600 : 20'h00500)));

    // R7: the upper half of the saved status is clear
    assert_srr1_upper_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        taken_o |-> (srr1_o[31:16] == 16'h0));

    // R8: only the kept or derived bits may be set in the new state word
    assert_msr_clear_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        taken_o |-> ((msr_o & ~MSR_MAY_SET) == 32'h0));

    // R9: the pulse lasts one cycle unless a new cause keeps it
    assert_pulse_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (taken_o && !$past(mem_fault_o) && !($past(irq_req_i) && $past(msr_i[MSR_EE])))
        |-> 1'b0);

    // R9: the registered results hold while no entry happens
    assert_hold_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !taken_o |-> ($stable(srr0_o) && $stable(srr1_o) && $stable(msr_o) && $stable(vec_o)));

endmodule

bind exc_entry_seq exc_entry_seq_chk u_chk (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .irq_req_i     (irq_req_i),
    .msr_i         (msr_i),
    .mem_fault_o   (mem_fault_o),
    .taken_o       (taken_o),
    .cause_align_o (cause_align_o),
    .vec_o         (vec_o),
    .srr0_o        (srr0_o),
    .srr1_o        (srr1_o),
    .msr_o         (msr_o)
);

// File: tb/exc_entry_seq_tb_top.sv
module exc_entry_seq_tb_top;

    localparam int TB_EE  = 15;
    localparam int TB_ILE = 16;
    localparam int TB_ME  = 12;
    localparam int TB_IP  = 6;
    localparam int TB_CE  = 2;
    localparam int TB_LE  = 0;

    typedef struct packed {
        logic        irq;
        logic        valid;
        logic [2:0]  cls;
        logic [31:0] ea;
        logic [31:0] msr;
        logic        en;
        logic        exc;
    } tv_t;

    localparam int NV = 13;
    localparam tv_t TV [NV] = '{
        '{1'b1, 1'b0, 3'd0, 32'h0,        32'h0000_8000, 1'b0, 1'b0}, // ext, EE set
        '{1'b1, 1'b0, 3'd0, 32'h0,        32'hFFFF_7FFF, 1'b1, 1'b1}, // EE clear
        '{1'b0, 1'b1, 3'd2, 32'h0000_2002, 32'hFFFF_FFFF, 1'b1, 1'b0}, // fp misaligned
        '{1'b0, 1'b1, 3'd2, 32'h0000_2100, 32'hFFFF_FFFF, 1'b1, 1'b1}, // fp aligned
        '{1'b0, 1'b1, 3'd3, 32'h0000_0101, 32'h0000_1041, 1'b1, 1'b1}, // lsm misaligned
        '{1'b0, 1'b1, 3'd3, 32'h0000_0104, 32'h0000_1041, 1'b0, 1'b1}, // lsm aligned
        '{1'b0, 1'b1, 3'd4, 32'h0000_0003, 32'h0001_0002, 1'b1, 1'b1}, // lrsc misaligned
        '{1'b0, 1'b1, 3'd4, 32'h0000_0008, 32'h0001_0002, 1'b1, 1'b1}, // lrsc aligned
        '{1'b0, 1'b1, 3'd1, 32'h0000_0001, 32'hFFFF_7FFF, 1'b1, 1'b1}, // integer misaligned
        '{1'b0, 1'b1, 3'd0, 32'h0000_0001, 32'hFFFF_7FFF, 1'b1, 1'b1}, // class none
        '{1'b0, 1'b0, 3'd2, 32'h0000_0003, 32'hFFFF_7FFF, 1'b1, 1'b1}, // not valid
        '{1'b1, 1'b1, 3'd2, 32'h0000_0001, 32'h0000_8040, 1'b0, 1'b1}, // collision
        '{1'b1, 1'b0, 3'd0, 32'h0,        32'h0001_8042, 1'b1, 1'b0}  // ext, ILE+IP+RI
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        irq = 1'b0, valid = 1'b0, en = 1'b0, exc = 1'b0;
    logic [2:0]  cls = 3'd0;
    logic [31:0] ea = '0, cur_pc = '0, next_pc = '0, msr = '0;
    logic        fault, taken, cause;
    logic [31:0] vec, srr0, srr1, msr_out;

    int n_chk = 0;
    int n_bad = 0;

    always #4 clk = ~clk;

    exc_entry_seq dut_i (
        .clk_i (clk), .rst_ni (rst_n), .irq_req_i (irq), .mem_valid_i (valid),
        .mem_cls_i (cls), .mem_ea_i (ea), .cur_pc_i (cur_pc), .next_pc_i (next_pc),
        .msr_i (msr), .cfg_cmp_en_i (en), .cfg_cmp_exc_i (exc),
        .mem_fault_o (fault), .taken_o (taken), .cause_align_o (cause),
        .vec_o (vec), .srr0_o (srr0), .srr1_o (srr1), .msr_o (msr_out)
    );

    task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    function automatic logic [31:0] ref_msr(input logic [31:0] m, input logic e, input logic x);
        logic [31:0] r = '0;
        r[TB_IP] = m[TB_IP];
        r[TB_ME] = m[TB_ME];
        r[TB_LE] = m[TB_ILE];
        r[TB_CE] = e & x;
        return r;
    endfunction

    logic [31:0] e_vec = '0, e_srr0 = '0, e_srr1 = '0, e_msr = '0;
    logic        e_cause = 1'b0;

    task automatic check_regs(input string tag);
        check({tag, " R6 srr0"}, srr0, e_srr0);
        check({tag, " R7 srr1"}, srr1, e_srr1);
        check({tag, " R8 msr"}, msr_out, e_msr);
        check({tag, " R5 vec"}, vec, e_vec);
        check({tag, " R4 cause"}, {31'd0, cause}, {31'd0, e_cause});
    endtask

    initial begin : watchdog
        #200000;
        n_bad++;
        $display("FAIL watchdog expired");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        // R1 reset state
        check("R1 taken", {31'd0, taken}, 32'd0);
        check_regs("R1");
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 taken after release", {31'd0, taken}, 32'd0);
        check_regs("R1 after release");

        for (int i = 0; i < NV; i++) begin
            logic exp_fault, exp_irq, exp_take;
            irq = TV[i].irq; valid = TV[i].valid; cls = TV[i].cls; ea = TV[i].ea;
            msr = TV[i].msr; en = TV[i].en; exc = TV[i].exc;
            cur_pc = 32'h0000_4000 + 32'(i) * 32'h10;
            next_pc = cur_pc + 32'd4;
            exp_fault = TV[i].valid && (TV[i].cls inside {3'd2, 3'd3, 3'd4}) && (TV[i].ea[1:0] != 2'b00);
            exp_irq   = TV[i].irq && TV[i].msr[TB_EE];
            exp_take  = exp_fault || exp_irq;
            #1;
            check("R2 fault", {31'd0, fault}, {31'd0, exp_fault});
            if (exp_take) begin
                e_cause = exp_fault;
                e_srr0  = exp_fault ? cur_pc : next_pc;
                e_srr1  = {16'h0, TV[i].msr[15:0]};
                e_msr   = ref_msr(TV[i].msr, TV[i].en, TV[i].exc);
                e_vec   = (TV[i].msr[TB_IP] ? 32'hFFF0_0000 : 32'h0)
                          + (exp_fault ? 32'h600 : 32'h500);
            end
            @(negedge clk);
            check("R3 R9 taken", {31'd0, taken}, {31'd0, exp_take});
            check_regs("R9 vector");
        end

        // R9: idle cycles, pulse drops and results hold
        irq = 1'b1; valid = 1'b0; msr = 32'h0000_0040;
        @(negedge clk);
        check("R9 pulse drop", {31'd0, taken}, 32'd0);
        check_regs("R9 hold");
        @(negedge clk);
        check("R3 EE clear still idle", {31'd0, taken}, 32'd0);
        check_regs("R9 hold2");

        // R1: reset in the middle clears everything
        rst_n = 1'b0;
        #1;
        e_vec = '0; e_srr0 = '0; e_srr1 = '0; e_msr = '0; e_cause = 1'b0;
        check("R1 mid reset taken", {31'd0, taken}, 32'd0);
        check_regs("R1 mid reset");

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule